// File: doc/BRIEF.md
# Kernel-Only Pipelined Loop Sequencer

This block steps a pipelined loop through a fixed number of stages. The same stage schedule serves both the fill phase and the steady state. A one-hot-per-stage predicate vector marks which stages hold a live iteration. After a start, one new iteration enters stage 0 on every cycle, and the predicate vector fills from the bottom. Stages that the first iteration has not yet reached stay disabled, so no separate fill-phase code is needed.

The loop has no known trip count. Each iteration reports its exit decision when it reaches the final stage. An iteration in the final stage commits. If it commits with its exit flag set, every younger iteration behind it is discarded in that same cycle, so no drain phase is needed. A one-cycle done pulse follows, and the sequencer then returns to idle.

Top module: `loop_seq`

## Requirements
- R1: After reset, `stage_en`, `commit`, `prologue`, `done` and `busy` are all 0.
- R2: A `start` seen while idle makes the next cycle running. In that cycle `busy` is 1 and `stage_en` has only bit 0 (stage 0) set.
- R3: In each running cycle without an exiting commit, the next `stage_en` is the current value shifted up one stage with bit 0 set. `stage_en` reaches all ones after NSTAGE-1 such cycles.
- R4: While running, `commit` is 1 exactly when the top stage bit of `stage_en` is 1. `prologue` is 1 exactly when the sequencer is running and that bit is 0.
- R5: `exit_flag` is used only in a cycle where `commit` is 1. In any other cycle it has no effect.
- R6: When `commit` and `exit_flag` are both 1, the next cycle has `stage_en` all zero, `commit` 0 and `done` 1. No squashed iteration ever raises `commit`.
- R7: `done` lasts one cycle. The cycle after it is idle, with `busy` 0, and a new `start` is accepted from then on.
- R8: `start` has no effect while `busy` is 1, including during the done cycle.
- R9: With NSTAGE = 1, `prologue` is never 1 and `commit` is 1 in every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the loop (accepted when idle) |
| exit_flag | input | 1 | Exit decision of the iteration in the final stage |
| stage_en | output | NSTAGE | Per-stage live-iteration predicates |
| commit | output | 1 | Iteration in the final stage retires this cycle |
| prologue | output | 1 | Pipeline still filling |
| done | output | 1 | One-cycle pulse after the exiting commit |
| busy | output | 1 | Running or in the done cycle |

## Verification
The hardest case to reach is an exit decision that arrives while younger iterations are already in flight, together with inputs that must be ignored. The stimulus has to place `exit_flag` exactly in the chosen commit cycle while holding it high during fill cycles, and it has to pulse `start` both mid-run and in the done cycle. The directed tasks count commits against a model of the fill and raise the exit on the k-th commit, for k of 1 and several larger values. A second instance with a single stage covers the case where there is no fill phase.

// File: rtl/loop_seq.sv
module loop_seq #(
  parameter int NSTAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              exit_flag,
  output logic [NSTAGE-1:0] stage_en,
  output logic              commit,
  output logic              prologue,
  output logic              done,
  output logic              busy
);

  logic              running_q, done_q;
  logic [NSTAGE-1:0] pred_q, pred_adv;

  generate
    if (NSTAGE == 1) begin : g_one
      assign pred_adv = 1'b1;
    end else begin : g_many
      assign pred_adv = {pred_q[NSTAGE-2:0], 1'b1};
    end
  endgenerate

  assign stage_en = pred_q;
  assign commit   = running_q & pred_q[NSTAGE-1];
  assign prologue = running_q & ~pred_q[NSTAGE-1];
  assign done     = done_q;
  assign busy     = running_q | done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      pred_q    <= '0;
    end else if (!busy && start) begin
      running_q <= 1'b1;
      pred_q    <= NSTAGE'(1);
    end else if (running_q) begin
      if (commit && exit_flag) begin
        running_q <= 1'b0;
        done_q    <= 1'b1;
        pred_q    <= '0;
      end else begin
        pred_q <= pred_adv;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  initial assert (NSTAGE >= 1 && NSTAGE <= 16);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (stage_en == '0 && !commit && !prologue));
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && stage_en == NSTAGE'(1)));
  a_r3_fill_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && !(commit && exit_flag)) |=> stage_en[0]);
  a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_en & (stage_en + NSTAGE'(1))) == '0));
  a_r6_squash: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && exit_flag) |=> (stage_en == '0 && !commit && done));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stage_en == '0);
endmodule

// File: tb/loop_seq_tb_top.sv
module loop_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st4 = 1'b0, ex4 = 1'b0, st1 = 1'b0, ex1 = 1'b0;
  logic [3:0] en4;
  logic [0:0] en1;
  logic cm4, pr4, dn4, bz4, cm1, pr1, dn1, bz1;
  int total = 0, bad = 0;
  logic wd_hit = 1'b0;

  always #5 clk = ~clk;

  loop_seq #(.NSTAGE(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(st4), .exit_flag(ex4),
    .stage_en(en4), .commit(cm4), .prologue(pr4), .done(dn4), .busy(bz4));

  loop_seq #(.NSTAGE(1)) dut_one_i (
    .clk(clk), .rst_n(rst_n), .start(st1), .exit_flag(ex1),
    .stage_en(en1), .commit(cm1), .prologue(pr1), .done(dn1), .busy(bz1));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int g_en(bit one);
    return one ? int'(en1) : int'(en4);
  endfunction
  function automatic int g_cm(bit one); return one ? int'(cm1) : int'(cm4); endfunction
  function automatic int g_pr(bit one); return one ? int'(pr1) : int'(pr4); endfunction
  function automatic int g_dn(bit one); return one ? int'(dn1) : int'(dn4); endfunction
  function automatic int g_bz(bit one); return one ? int'(bz1) : int'(bz4); endfunction

  task automatic set_in(bit one, bit s, bit e);
    if (one) begin st1 = s; ex1 = e; end
    else begin st4 = s; ex4 = e; end
  endtask

  task automatic run_loop(input bit one, input int k, input bit noise);
    int n = one ? 1 : 4;
    int commits = 0;
    bit leave = 0;
    set_in(one, 1'b1, 1'b0);
    @(negedge clk);
    set_in(one, 1'b0, 1'b0);
    for (int t = 0; t < 200 && !leave; t++) begin
      int fill = (t + 1 < n) ? t + 1 : n;
      int ecm = (t >= n - 1) ? 1 : 0;
      bit s = 0, e = 0;
      chk("R2/R3 stage_en", g_en(one), (1 << fill) - 1);
      chk("R4 commit", g_cm(one), ecm);
      chk(one ? "R9 prologue" : "R4 prologue", g_pr(one), 1 - ecm);
      chk("R2 busy", g_bz(one), 1);
      chk("R7 done low while running", g_dn(one), 0);
      if (ecm == 1) begin
        commits++;
        if (commits == k) begin e = 1; leave = 1; end
      end else if (noise) begin
        e = 1;  // R5: ignored outside commit
      end
      if (noise && t == 1) s = 1;  // R8: ignored while busy
      set_in(one, s, e);
      @(negedge clk);
      set_in(one, 1'b0, 1'b0);
    end
    chk("R6 stage_en cleared", g_en(one), 0);
    chk("R6 no squashed commit", g_cm(one), 0);
    chk("R6 done", g_dn(one), 1);
    chk("R6 commit count", commits, k);
    if (noise) set_in(one, 1'b1, 1'b0);  // R8: ignored in done cycle
    @(negedge clk);
    set_in(one, 1'b0, 1'b0);
    chk("R7 idle after done", g_bz(one), 0);
    chk("R7 done one cycle", g_dn(one), 0);
    chk("R8 start ignored in done", g_en(one), 0);
    @(negedge clk);
    chk("R8 still idle", g_bz(one), 0);
  endtask

  task automatic test_reset();
    chk("R1 stage_en", int'(en4), 0);
    chk("R1 commit", int'(cm4), 0);
    chk("R1 prologue", int'(pr4), 0);
    chk("R1 done", int'(dn4), 0);
    chk("R1 busy", int'(bz4), 0);
  endtask

  task automatic test_idle_exit();
    set_in(1'b0, 1'b0, 1'b1);  // R5: exit while idle has no effect
    @(negedge clk);
    set_in(1'b0, 1'b0, 1'b0);
    chk("R5 idle exit ignored", int'(bz4), 0);
    chk("R5 idle stage_en", int'(en4), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    wd_hit = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_exit();
        run_loop(1'b0, 1, 1'b0);
        run_loop(1'b0, 3, 1'b0);
        run_loop(1'b0, 5, 1'b1);
        run_loop(1'b0, 1, 1'b1);
        run_loop(1'b1, 1, 1'b0);
        run_loop(1'b1, 4, 1'b1);
        run_loop(1'b0, 2, 1'b0);
      end
      begin
        wait (wd_hit);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule